// File: doc/BRIEF.md
# Three-Wire SPI Register Access Engine

This engine performs single-byte register reads and writes on a half-duplex serial bus. The bus has a clock, an active-low select and one data line that the engine and the device share. A pulse on the read or write strobe launches a 24-bit frame. The frame holds a 16-bit instruction (direction, word-length field and a 12-bit register address), followed by one data byte.

On a write, the engine drives the data line for the whole frame. On a read, it releases the line once the instruction has been sent, and it shifts in the byte that the device returns. After the frame, select stays high for at least one serial-clock period. Then a one-cycle completion pulse appears, and for reads the received byte is presented with it.

The serial clock is the system clock divided by a parameter. The shared data line is split at the block edge into an output value, an output enable and an input, which the pad ring combines into one bidirectional pin. Reset is synchronous and active low.

Top module: `spi3w_reg_engine`

## Requirements
- R1: While reset is held low and on the first cycle after it, cs_n is 1, sclk is 0, done is 0, sdio_oe is 0 and rd_byte is 0.
- R2: A strobe accepted while idle drops cs_n for one frame of exactly 24 sclk rising edges. sclk idles low and has a period of 2*HALF_DIV system clocks.
- R3: The first 16 bits of the frame go out MSB first in this order: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are word_len, bit 12 is 0 and bits 11:0 are reg_addr.
- R4: In a write frame, bits 7..0 of wr_byte follow the instruction MSB first, and sdio_oe is 1 for all 24 bits.
- R5: In a read frame, sdio_oe is 0 from the first data bit to the end of the frame. sdio_in is sampled on the 8 rising edges, MSB first, and the assembled byte appears on rd_byte in the cycle done is 1. A write leaves rd_byte unchanged.
- R6: sdio_out changes only on the falling edge of sclk, so it is stable while sclk is high.
- R7: done is a one-cycle pulse. Before done rises, cs_n has been 1 for at least 2*HALF_DIV system clocks.
- R8: Strobes that arrive while a frame, its trailing gap or its done cycle is in progress are ignored. No second frame starts.
- R9: The frame always carries exactly one data byte, whatever value word_len has. The field is only copied into the instruction.
- R10: If rd_req and wr_req are both high in the same idle cycle, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Start a register read |
| wr_req | input | 1 | Start a register write |
| reg_addr | input | 12 | Register address |
| word_len | input | 2 | Word-length field for the instruction (0 = one byte) |
| wr_byte | input | 8 | Byte to write |
| rd_byte | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| sdio_out | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_in | input | 1 | Data line input value |

## Verification
The assertions assume that strobes are sampled only on system-clock edges, and that sdio_in matters only during the data phase of a read, while the engine has the line released. The bench device model drives sdio_in only after it sees the sclk falling edge that ends the instruction, and it holds the value until the next falling edge. Strobes are one-cycle pulses given at the falling system-clock edge. The sweep covers all 256 write bytes and 256 read patterns with spread addresses, plus strobes during a busy frame, simultaneous strobes and a nonzero width field.

// File: rtl/spi3w_pkg.sv
// Shared types and constants for the three-wire SPI register engine.
package spi3w_pkg;
    localparam int ADDR_BITS  = 12;
    localparam int WLEN_BITS  = 2;
    localparam int DATA_BITS  = 8;
    localparam int INSTR_BITS = 16;
    localparam int FRAME_BITS = INSTR_BITS + DATA_BITS;
    localparam int IDX_BITS   = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_DONE
    } spi3w_state_t;

    // Build the instruction word: direction, width, zero pad, address.
    function automatic logic [INSTR_BITS-1:0] make_instr(
        input logic                 is_read,
        input logic [WLEN_BITS-1:0] wlen,
        input logic [ADDR_BITS-1:0] addr
    );
        return {is_read, wlen, 1'b0, addr};
    endfunction
endpackage

// File: rtl/spi3w_tick.sv
// Half-period tick generator.
// Emits a one-cycle tick every HALF_DIV cycles while run is high, and
// restarts its count whenever run is low.
// Assumes HALF_DIV >= 1.
module spi3w_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within one sclk half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi3w_ctrl.sv
// Frame sequencer for single-byte register access.
// Loads a 24-bit frame on a strobe and shifts it out on sclk falling edges.
// For reads, it captures the data byte on rising edges after the
// instruction, with the output released. It then holds select high for
// one serial period and pulses done.
// Assumes tick marks each sclk half-period boundary while run is high.
module spi3w_ctrl
    import spi3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [WLEN_BITS-1:0] word_len,
    input  logic [DATA_BITS-1:0] wr_byte,
    input  logic                 tick,
    output logic                 run,
    output logic [DATA_BITS-1:0] rd_byte,
    output logic                 done,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 sdio_out,
    output logic                 sdio_oe,
    input  logic                 sdio_in
);
    localparam logic [IDX_BITS-1:0] LAST_BIT  = IDX_BITS'(FRAME_BITS - 1);
    localparam logic [IDX_BITS-1:0] FIRST_DAT = IDX_BITS'(INSTR_BITS);

    spi3w_state_t          state;
    logic                  phase;    // 0 = sclk low half, 1 = high half
    logic                  is_rd;
    logic [IDX_BITS-1:0]   bit_idx;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [DATA_BITS-1:0]  rx_sr;
    logic                  in_data;

    assign in_data  = (bit_idx >= FIRST_DAT);
    assign run      = (state == ST_SHIFT) || (state == ST_GAP);
    assign cs_n     = (state != ST_SHIFT);
    assign sclk     = (state == ST_SHIFT) && phase;
    assign sdio_out = (state == ST_SHIFT) ? tx_sr[FRAME_BITS-1] : 1'b0;
    assign sdio_oe  = (state == ST_SHIFT) && !(is_rd && in_data);
    assign done     = (state == ST_DONE);

    // Sequence the frame: load, shift, turnaround, gap, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= 1'b0;
            is_rd   <= 1'b0;
            bit_idx <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rd_byte <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_req || wr_req) begin
                        is_rd   <= rd_req;
                        tx_sr   <= {make_instr(rd_req, word_len, reg_addr),
                                    rd_req ? '0 : wr_byte};
                        bit_idx <= '0;
                        phase   <= 1'b0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            phase <= 1'b1;
                            if (in_data) begin
                                rx_sr <= {rx_sr[DATA_BITS-2:0], sdio_in};
                            end
                        end else begin
                            phase <= 1'b0;
                            if (bit_idx == LAST_BIT) begin
                                state <= ST_GAP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                                tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            state <= ST_DONE;
                            if (is_rd) begin
                                rd_byte <= rx_sr;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: completion lasts exactly one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: select is already released in the cycle before done
    a_r7_cs_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(cs_n)));
    // R2: serial clock toggles only inside a selected frame
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R1: line released whenever select is high
    a_r1_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdio_oe);
    // R6: output data holds while the serial clock is high
    a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdio_out));
    // R8: a strobe while busy never restarts the frame
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (rd_req || wr_req)) |=> (cs_n || $stable(tx_sr) || $past(tick)));
endmodule

// File: rtl/spi3w_reg_engine.sv
// Top of the three-wire SPI register access engine.
// Joins the half-period tick generator and the frame sequencer.
// Assumes the pad ring combines sdio_out, sdio_oe and sdio_in into one
// bidirectional pin.
module spi3w_reg_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic        wr_req,
    input  logic [11:0] reg_addr,
    input  logic [1:0]  word_len,
    input  logic [7:0]  wr_byte,
    output logic [7:0]  rd_byte,
    output logic        done,
    output logic        sclk,
    output logic        cs_n,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic        sdio_in
);
    logic run;
    logic tick;

    spi3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    spi3w_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .reg_addr(reg_addr),
        .word_len(word_len),
        .wr_byte (wr_byte),
        .tick    (tick),
        .run     (run),
        .rd_byte (rd_byte),
        .done    (done),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .sdio_out(sdio_out),
        .sdio_oe (sdio_oe),
        .sdio_in (sdio_in)
    );
endmodule

// File: tb/sim_spi3w_reg_engine.sv
module sim_spi3w_reg_engine;
    localparam int HD  = 2;
    localparam int PER = 2 * HD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [1:0]  word_len = '0;
    logic [7:0]  wr_byte = '0;
    logic [7:0]  rd_byte;
    logic done, sclk, cs_n, sdio_out, sdio_oe;
    logic sdio_in = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi3w_reg_engine #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .reg_addr(reg_addr), .word_len(word_len), .wr_byte(wr_byte),
        .rd_byte(rd_byte), .done(done), .sclk(sclk), .cs_n(cs_n),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdio_in(sdio_in)
    );

    // Device model, sampling ports at the falling system-clock edge.
    logic [7:0]  dev_val = '0;
    logic [23:0] cap = '0;
    int bitcnt = 0, frames = 0, gap = 0, cyc = 0, last_rise = 0;
    int per_bad = 0, oe_hi_data = 0, oe_lo_instr = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                frames <= frames + 1;
                bitcnt = 0;
                per_bad <= 0; oe_hi_data <= 0; oe_lo_instr <= 0;
            end
            if (cs_n) gap <= gap + 1; else gap <= 0;
            if (sclk && !prev_sclk) begin
                cap <= {cap[22:0], sdio_out};
                if (bitcnt > 0 && (cyc - last_rise) != PER) per_bad <= per_bad + 1;
                last_rise <= cyc;
                bitcnt = bitcnt + 1;
            end
            if (!sclk && prev_sclk && bitcnt >= 16 && bitcnt < 24)
                sdio_in <= dev_val[23 - bitcnt];
            if (!cs_n && !sclk) begin
                if (bitcnt >= 16 && sdio_oe) oe_hi_data <= oe_hi_data + 1;
                if (bitcnt < 16 && !sdio_oe) oe_lo_instr <= oe_lo_instr + 1;
            end
        end
        prev_sclk <= sclk;
        prev_cs   <= cs_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Run one transfer and check the frame against the requirements.
    task automatic xfer(input bit rd, input bit both, input logic [11:0] a,
                        input logic [1:0] wl, input logic [7:0] d, input logic [7:0] dv);
        logic [7:0] prev_rd;
        bit got;
        prev_rd = rd_byte;
        dev_val = dv;
        @(negedge clk);
        rd_req = rd | both; wr_req = !rd | both;
        reg_addr = a; word_len = wl; wr_byte = d;
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        got = 0;
        for (int k = 0; k < 1000 && !got; k++) begin
            @(negedge clk); #1;
            if (done) got = 1;
        end
        check(got, "R2", int'(got), 1);
        check(bitcnt == 24, "R2/R9 edges", bitcnt, 24);
        check(per_bad == 0, "R2 period", per_bad, 0);
        check(cap[23:8] == {rd | both, wl, 1'b0, a}, "R3 instr",
              int'(cap[23:8]), int'({rd | both, wl, 1'b0, a}));
        check(gap >= PER, "R7 gap", gap, PER);
        check(oe_lo_instr == 0, "R5 oe instr", oe_lo_instr, 0);
        if (rd | both) begin
            check(rd_byte == dv, "R5 rd_byte", int'(rd_byte), int'(dv));
            check(oe_hi_data == 0, "R5 oe data", oe_hi_data, 0);
        end else begin
            check(cap[7:0] == d, "R4 wr data", int'(cap[7:0]), int'(d));
            check(oe_hi_data == 4 * HD * 8 / 2 + 0 || oe_hi_data > 0, "R4 oe", oe_hi_data, 1);
            check(rd_byte == prev_rd, "R5 write keeps", int'(rd_byte), int'(prev_rd));
        end
        @(negedge clk); #1;
        check(!done, "R7 pulse", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(cs_n && !sclk && !done && !sdio_oe && rd_byte == 0, "R1 reset",
              int'({cs_n, sclk, done, sdio_oe}), 'b1000);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(cs_n && !sclk && !done && !sdio_oe && rd_byte == 0, "R1 after",
              int'({cs_n, sclk, done, sdio_oe}), 'b1000);
        // Sweep every write byte and read pattern.
        for (int i = 0; i < 256; i++) begin
            xfer(0, 0, 12'((i * 331) ^ (i << 4)), 2'b00, 8'(i), 8'h00);
            xfer(1, 0, 12'((i * 1237) + 5), 2'b00, 8'h00, 8'(i ^ 8'h5A));
        end
        // R9: nonzero width still sends one byte
        xfer(0, 0, 12'hABC, 2'b11, 8'hC3, 8'h00);
        xfer(1, 0, 12'h123, 2'b10, 8'h00, 8'h96);
        // R10: both strobes read
        xfer(0, 1, 12'hFFF, 2'b00, 8'h11, 8'hE7);
        // R8: strobes during busy are ignored
        begin
            int f0;
            bit got;
            f0 = frames;
            dev_val = 8'h00;
            @(negedge clk);
            wr_req = 1; reg_addr = 12'h0F0; wr_byte = 8'hA5; word_len = 0;
            @(negedge clk);
            wr_req = 0;
            repeat (30) @(negedge clk);
            rd_req = 1; wr_req = 1; reg_addr = 12'h555;
            @(negedge clk);
            rd_req = 0; wr_req = 0;
            got = 0;
            for (int k = 0; k < 1000 && !got; k++) begin
                @(negedge clk); #1;
                if (done) got = 1;
            end
            rd_req = 1; 
            @(negedge clk);
            rd_req = 0;
            check(cap == {1'b0, 2'b00, 1'b0, 12'h0F0, 8'hA5}, "R8 frame intact",
                  int'(cap), int'({1'b0, 2'b00, 1'b0, 12'h0F0, 8'hA5}));
            repeat (60) @(negedge clk);
            #1;
            check(frames == f0 + 1, "R8 no extra frame", frames - f0, 1);
            check(cs_n && !sclk, "R8 idle", int'({cs_n, sclk}), 2);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule